// File: doc/BRIEF.md
# Disk Controller Interrupt Cause Tracker

This block drives the single interrupt line of a floppy disk controller and keeps a record of why that line was raised. Interrupt sources fall into two classes. The first class covers data-phase events: entry into the result phase of a data command, and each transfer request made during a non-DMA execution phase. The host clears this class with an ordinary data read or write. The second class covers drive events: the end of a seek or recalibrate, and a change on a drive's ready line. These are latched separately for each drive. They stay latched until a sense-interrupt-status command drains them one at a time into a status byte.

The block also produces the non-DMA execution status bit. That bit is set when a non-DMA execution phase begins and is cleared when the result phase is entered. The status byte holds four fields:
- a two-bit termination code in bits 7:6;
- seek-end in bit 5;
- equipment-check in bit 4;
- the drive number in bits 1:0.

Command decoding and data movement belong to neighbouring logic. That logic supplies single-cycle event pulses to this block.

Top module: `fdc_irq_tracker`

## Requirements
- R1: After reset, `irq_o` is 0, `exec_o` is 0 and `st0_o` is 8'h00.
- R2: A pulse on `result_enter_i` raises `irq_o` on the next cycle and clears `exec_o`.
- R3: A pulse on `exec_begin_i` sets `exec_o`. A pulse on `xfer_req_i` while `exec_o` is 1 raises `irq_o`. A pulse on `xfer_req_i` while `exec_o` is 0 has no effect and leaves `irq_o` low.
- R4: A pulse on `host_access_i` clears a data-class interrupt. It leaves latched drive events pending, so `irq_o` stays 1 while any drive event remains.
- R5: A seek end on drive d without equipment check is latched, and `irq_o` stays 1 until it is sensed. The sense reports 8'h20|d, which is code 00, seek-end 1 and equipment-check 0.
- R6: A seek end that arrives with `eq_chk_i` set reports 8'h70|d, which is code 01, seek-end 1 and equipment-check 1.
- R7: A ready-line change on drive d reports 8'hC0|d, which is code 11 with seek-end and equipment-check both 0.
- R8: Each sense reports exactly one pending event. The lowest-numbered drive is reported first, and within one drive the seek event comes before the ready event. `irq_o` stays 1 until the last pending event has been reported.
- R9: A sense issued with no drive event pending reports 8'h80, the invalid code 10.
- R10: A sense also clears a data-class interrupt. `st0_o` changes only on a sense and holds its value between senses.
- R11: If a new event arrives for a drive in the same cycle that a sense drains that drive's event of the same kind, the new event stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_begin_i | input | 1 | Pulse: a non-DMA execution phase starts |
| xfer_req_i | input | 1 | Pulse: data transfer request in the non-DMA execution phase |
| result_enter_i | input | 1 | Pulse: the result phase of a data command is entered |
| host_access_i | input | 1 | Pulse: the host reads or writes the data port |
| sense_i | input | 1 | Pulse: a sense-interrupt-status command is issued |
| seek_end_i | input | NUM_DRIVES | Per-drive pulse: a seek or recalibrate has finished |
| eq_chk_i | input | NUM_DRIVES | Per-drive qualifier of `seek_end_i`: the operation failed |
| rdy_chg_i | input | NUM_DRIVES | Per-drive pulse: the ready line changed state |
| irq_o | output | 1 | Interrupt line |
| exec_o | output | 1 | Non-DMA execution status bit |
| st0_o | output | 8 | Status byte loaded by each sense |

## Verification
The drain order is tested with one simultaneous burst that mixes drive numbers and event kinds. This separates drive-index priority from the seek-before-ready order inside a single drive. Single events of each kind (normal seek, failed recalibrate, ready change) confirm the field encoding. A sense with nothing pending confirms the invalid code. Interleaved host accesses and senses show that each clearing action affects only its own class. A set that collides with a drain on the same drive shows that a new event survives the cycle in which an older one is read out.

// File: rtl/fdc_irq_pkg.sv
package fdc_irq_pkg;
  typedef enum logic [1:0] {
    TERM_NORMAL   = 2'b00,
    TERM_ABNORMAL = 2'b01,
    TERM_INVALID  = 2'b10,
    TERM_READY    = 2'b11
  } term_e;

  // Status byte: {term[1:0], seek_end, eq_chk, 2'b00, drive[1:0]}
  function automatic logic [7:0] st0_pack(term_e term, logic se, logic ec, logic [1:0] drv);
    return {term, se, ec, 2'b00, drv};
  endfunction
endpackage

// File: rtl/fdc_drive_evt.sv
module fdc_drive_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic seek_end_i,
  input  logic eq_chk_i,
  input  logic rdy_chg_i,
  input  logic clr_seek_i,
  input  logic clr_rdy_i,
  output logic seek_pend_o,
  output logic seek_fail_o,
  output logic rdy_pend_o
);
  logic seek_pend_q, seek_pend_d;
  logic seek_fail_q, seek_fail_d;
  logic rdy_pend_q, rdy_pend_d;

  always_comb begin
    seek_pend_d = seek_pend_q;
    seek_fail_d = seek_fail_q;
    rdy_pend_d  = rdy_pend_q;
    if (clr_seek_i) begin
      seek_pend_d = 1'b0;
      seek_fail_d = 1'b0;
    end
    if (seek_end_i) begin
      seek_pend_d = 1'b1;
      seek_fail_d = eq_chk_i;
    end
    if (clr_rdy_i) rdy_pend_d = 1'b0;
    if (rdy_chg_i) rdy_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seek_pend_q <= 1'b0;
      seek_fail_q <= 1'b0;
      rdy_pend_q  <= 1'b0;
    end else begin
      seek_pend_q <= seek_pend_d;
      seek_fail_q <= seek_fail_d;
      rdy_pend_q  <= rdy_pend_d;
    end
  end

  assign seek_pend_o = seek_pend_q;
  assign seek_fail_o = seek_fail_q;
  assign rdy_pend_o  = rdy_pend_q;

  // R11
  seek_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seek_end_i |=> seek_pend_o);

  // R6
  fail_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seek_end_i && eq_chk_i) |=> (seek_pend_o && seek_fail_o));

  // R7
  rdy_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_chg_i |=> rdy_pend_o);
endmodule

// File: rtl/fdc_evt_arbiter.sv
module fdc_evt_arbiter #(
  parameter int NUM_DRIVES = 4,
  localparam int IDX_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic [NUM_DRIVES-1:0] seek_pend_i,
  input  logic [NUM_DRIVES-1:0] rdy_pend_i,
  output logic                  found_o,
  output logic                  is_seek_o,
  output logic [IDX_W-1:0]      drv_o
);
  // Scan from the top so that the lowest drive wins; seek overrides ready within a drive.
  always_comb begin
    found_o   = 1'b0;
    is_seek_o = 1'b0;
    drv_o     = '0;
    for (int d = NUM_DRIVES - 1; d >= 0; d--) begin
      if (rdy_pend_i[d]) begin
        found_o   = 1'b1;
        is_seek_o = 1'b0;
        drv_o     = IDX_W'(d);
      end
      if (seek_pend_i[d]) begin
        found_o   = 1'b1;
        is_seek_o = 1'b1;
        drv_o     = IDX_W'(d);
      end
    end
  end

  // R8
  always_comb begin
    if (found_o) begin
      grant_valid_chk: assert (is_seek_o ? seek_pend_i[drv_o] : rdy_pend_i[drv_o]);
    end
  end
endmodule

// File: rtl/fdc_data_irq.sv
module fdc_data_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic exec_begin_i,
  input  logic xfer_req_i,
  input  logic result_enter_i,
  input  logic host_access_i,
  input  logic sense_i,
  output logic data_irq_o,
  output logic exec_o
);
  logic exec_q, exec_d;
  logic irq_q, irq_d;
  logic irq_set, irq_clr;

  assign irq_set = result_enter_i | (xfer_req_i & exec_q);
  assign irq_clr = host_access_i | sense_i;

  always_comb begin
    exec_d = exec_q;
    if (exec_begin_i)   exec_d = 1'b1;
    if (result_enter_i) exec_d = 1'b0;
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (irq_set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      exec_q <= exec_d;
      irq_q  <= irq_d;
    end
  end

  assign exec_o     = exec_q;
  assign data_irq_o = irq_q;

  // R2
  result_clears_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_enter_i |=> (!exec_o && data_irq_o));

  // R3
  xfer_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req_i && exec_o) |=> data_irq_o);

  // R4
  host_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_access_i && !result_enter_i && !xfer_req_i) |=> !data_irq_o);
endmodule

// File: rtl/fdc_irq_tracker.sv
module fdc_irq_tracker
  import fdc_irq_pkg::*;
#(
  parameter int NUM_DRIVES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  exec_begin_i,
  input  logic                  xfer_req_i,
  input  logic                  result_enter_i,
  input  logic                  host_access_i,
  input  logic                  sense_i,
  input  logic [NUM_DRIVES-1:0] seek_end_i,
  input  logic [NUM_DRIVES-1:0] eq_chk_i,
  input  logic [NUM_DRIVES-1:0] rdy_chg_i,
  output logic                  irq_o,
  output logic                  exec_o,
  output logic [7:0]            st0_o
);
  localparam int IDX_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1;

  logic [NUM_DRIVES-1:0] seek_pend_w, seek_fail_w, rdy_pend_w;
  logic [NUM_DRIVES-1:0] clr_seek_w, clr_rdy_w;
  logic                  found_w, is_seek_w, data_irq_w;
  logic [IDX_W-1:0]      drv_w;
  logic [7:0]            st0_q, st0_d;

  fdc_data_irq u_data (
    .clk            (clk),
    .rst_n          (rst_n),
    .exec_begin_i   (exec_begin_i),
    .xfer_req_i     (xfer_req_i),
    .result_enter_i (result_enter_i),
    .host_access_i  (host_access_i),
    .sense_i        (sense_i),
    .data_irq_o     (data_irq_w),
    .exec_o         (exec_o)
  );

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
    fdc_drive_evt u_evt (
      .clk         (clk),
      .rst_n       (rst_n),
      .seek_end_i  (seek_end_i[g]),
      .eq_chk_i    (eq_chk_i[g]),
      .rdy_chg_i   (rdy_chg_i[g]),
      .clr_seek_i  (clr_seek_w[g]),
      .clr_rdy_i   (clr_rdy_w[g]),
      .seek_pend_o (seek_pend_w[g]),
      .seek_fail_o (seek_fail_w[g]),
      .rdy_pend_o  (rdy_pend_w[g])
    );
  end

  fdc_evt_arbiter #(.NUM_DRIVES(NUM_DRIVES)) u_arb (
    .seek_pend_i (seek_pend_w),
    .rdy_pend_i  (rdy_pend_w),
    .found_o     (found_w),
    .is_seek_o   (is_seek_w),
    .drv_o       (drv_w)
  );

  always_comb begin
    clr_seek_w = '0;
    clr_rdy_w  = '0;
    st0_d      = st0_q;
    if (sense_i) begin
      if (found_w) begin
        if (is_seek_w) begin
          clr_seek_w[drv_w] = 1'b1;
          st0_d = st0_pack(seek_fail_w[drv_w] ? TERM_ABNORMAL : TERM_NORMAL,
                           1'b1, seek_fail_w[drv_w], 2'(drv_w));
        end else begin
          clr_rdy_w[drv_w] = 1'b1;
          st0_d = st0_pack(TERM_READY, 1'b0, 1'b0, 2'(drv_w));
        end
      end else begin
        st0_d = st0_pack(TERM_INVALID, 1'b0, 1'b0, 2'b00);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st0_q <= 8'h00;
    else        st0_q <= st0_d;
  end

  assign st0_o = st0_q;
  assign irq_o = data_irq_w | (|seek_pend_w) | (|rdy_pend_w);

  // R9
  empty_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i && !found_w) |=> (st0_o == 8'h80));

  // R10
  st0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_i |=> $stable(st0_o));

  // R8
  drv_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i && found_w) |=> (st0_o[1:0] == 2'($past(drv_w))));

  // R5
  seek_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i && found_w && is_seek_w) |=> (st0_o[5] && st0_o[7] == 1'b0));
endmodule

// File: tb/tb_fdc_irq_tracker.sv
module tb_fdc_irq_tracker;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       exec_begin_i, xfer_req_i, result_enter_i, host_access_i, sense_i;
  logic [3:0] seek_end_i, eq_chk_i, rdy_chg_i;
  logic       irq_o, exec_o;
  logic [7:0] st0_o;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  fdc_irq_tracker #(.NUM_DRIVES(4)) dut (
    .clk(clk), .rst_n(rst_n), .exec_begin_i(exec_begin_i), .xfer_req_i(xfer_req_i),
    .result_enter_i(result_enter_i), .host_access_i(host_access_i), .sense_i(sense_i),
    .seek_end_i(seek_end_i), .eq_chk_i(eq_chk_i), .rdy_chg_i(rdy_chg_i),
    .irq_o(irq_o), .exec_o(exec_o), .st0_o(st0_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    exec_begin_i = 0; xfer_req_i = 0; result_enter_i = 0; host_access_i = 0;
    sense_i = 0; seek_end_i = '0; eq_chk_i = '0; rdy_chg_i = '0;
  endtask

  // One-cycle pulse of whatever was set before the call; returns at the sampling negedge.
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic sense_expect(string req, logic [7:0] code, logic irq_after);
    @(negedge clk); sense_i = 1; step();
    check(req, st0_o, code);
    check(req, {7'd0, irq_o}, {7'd0, irq_after});
  endtask

  task automatic t_reset();
    check("R1", {7'd0, irq_o}, 8'd0);
    check("R1", {7'd0, exec_o}, 8'd0);
    check("R1", st0_o, 8'h00);
  endtask

  task automatic t_data_class();
    @(negedge clk); xfer_req_i = 1; step();
    check("R3", {7'd0, irq_o}, 8'd0);            // ignored outside execution
    @(negedge clk); exec_begin_i = 1; step();
    check("R3", {7'd0, exec_o}, 8'd1);
    @(negedge clk); xfer_req_i = 1; step();
    check("R3", {7'd0, irq_o}, 8'd1);
    @(negedge clk); host_access_i = 1; step();
    check("R4", {7'd0, irq_o}, 8'd0);
    check("R3", {7'd0, exec_o}, 8'd1);
    @(negedge clk); result_enter_i = 1; step();
    check("R2", {7'd0, irq_o}, 8'd1);
    check("R2", {7'd0, exec_o}, 8'd0);
    @(negedge clk); host_access_i = 1; step();
    check("R4", {7'd0, irq_o}, 8'd0);
  endtask

  task automatic t_single_events();
    @(negedge clk); seek_end_i = 4'b0100; step();
    check("R5", {7'd0, irq_o}, 8'd1);
    @(negedge clk); host_access_i = 1; step();
    check("R4", {7'd0, irq_o}, 8'd1);
    sense_expect("R5", 8'h22, 1'b0);
    @(negedge clk); seek_end_i = 4'b0010; eq_chk_i = 4'b0010; step();
    sense_expect("R6", 8'h71, 1'b0);
    @(negedge clk); rdy_chg_i = 4'b1000; step();
    sense_expect("R7", 8'hC3, 1'b0);
    sense_expect("R9", 8'h80, 1'b0);
  endtask

  task automatic t_order();
    @(negedge clk); seek_end_i = 4'b1011; rdy_chg_i = 4'b0001; step();
    check("R8", {7'd0, irq_o}, 8'd1);
    sense_expect("R8", 8'h20, 1'b1);
    sense_expect("R8", 8'hC0, 1'b1);
    sense_expect("R8", 8'h21, 1'b1);
    sense_expect("R8", 8'h23, 1'b0);
    sense_expect("R9", 8'h80, 1'b0);
  endtask

  task automatic t_sense_data_and_hold();
    @(negedge clk); result_enter_i = 1; step();
    check("R10", {7'd0, irq_o}, 8'd1);
    sense_expect("R10", 8'h80, 1'b0);
    @(negedge clk); rdy_chg_i = 4'b0100; step();
    repeat (3) @(negedge clk);
    check("R10", st0_o, 8'h80);                   // no sense, byte holds
    sense_expect("R7", 8'hC2, 1'b0);
  endtask

  task automatic t_collision();
    @(negedge clk); seek_end_i = 4'b0001; step();
    @(negedge clk); sense_i = 1; seek_end_i = 4'b0001; step();
    check("R11", st0_o, 8'h20);
    check("R11", {7'd0, irq_o}, 8'd1);
    sense_expect("R11", 8'h20, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_data_class();
    t_single_events();
    t_order();
    t_sense_data_and_hold();
    t_collision();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule